// File: doc/BRIEF.md
# Communication Loss Watchdog

This block watches a bus slave for processed data-exchange and write-parameter requests. Once armed, it measures the time since the most recent such request. If that time reaches the timeout window, it lights a red status LED to report that no exchange is taking place. The next request of either kind turns the LED off and starts a new window.

The watchdog stays idle after reset. It arms on the first write-parameter request processed while the slave address is nonzero. From then on it stays armed until one of three things happens: a reset, a delete-address event, or the slave address dropping to zero. A prescaler derived from the clock frequency parameter gives a millisecond tick. The default timeout is 96 ms, which falls inside the allowed window of 94.2 ms to 98.2 ms.

Top module: `comm_loss_wdog`

## Requirements
- R1: After reset deasserts, led_red_o and active_o are both 0.
- R2: A write-parameter pulse sampled while slave_addr_i is nonzero sets active_o from the next cycle. A data-exchange pulse never arms the block. A write-parameter pulse at address 0 does not arm it either.
- R3: While armed with no further request, led_red_o rises exactly TIMEOUT_MS*(CLK_FREQ_HZ/1000) clock edges after the edge that sampled the last request, and not earlier.
- R4: A data-exchange pulse before the timeout keeps led_red_o low and restarts the full window from that pulse.
- R5: While led_red_o is high, any data-exchange or write-parameter pulse clears it in the next cycle and starts a new full window.
- R6: A request sampled on the same edge at which the timeout would expire wins: led_red_o stays 0 and a new window starts.
- R7: A delete-address pulse clears active_o and led_red_o in the next cycle. Later data-exchange pulses do not re-arm the block, and the LED stays off however long the bus stays quiet.
- R8: A slave address of zero disarms the block in the next cycle.
- R9: A delete-address pulse on the same edge as a write-parameter pulse leaves the block disarmed.
- R10: led_red_o is never 1 while active_o is 0. Default parameters place the timeout between 94.2 ms and 98.2 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, frequency CLK_FREQ_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dexg_done_i | input | 1 | One-cycle pulse: data-exchange request processed |
| wpar_done_i | input | 1 | One-cycle pulse: write-parameter request processed |
| del_addr_i | input | 1 | One-cycle pulse: delete-address request received |
| slave_addr_i | input | ADDR_W | Current slave address |
| led_red_o | output | 1 | Red LED drive, 1 = communication lost |
| active_o | output | 1 | Watchdog armed |

## Verification
Any internal fault shows up at the two outputs in one of a few ways. A prescaler or millisecond counter that is off by one moves the LED rising edge away from the exact cycle the window predicts, so the fault is visible on the expiry edge of the first window. A wrong arming or disarming decision shows on active_o one cycle after the pulse. A restart that fails to clear the counters shows as an LED that lights early, one window after a request. A lost request-versus-expiry priority shows as an LED pulse on the cycle after the collision.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {
    CW_OFF   = 2'b00,
    CW_WATCH = 2'b01,
    CW_LOST  = 2'b10
  } cw_state_e;

  localparam int unsigned TICKS_PER_SEC = 1000;
endpackage

// File: rtl/cw_ms_tick.sv
module cw_ms_tick #(
  parameter int unsigned DIV = 50_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_passthru
      assign tick_o = run_i & ~clr_i;
    end else begin : g_div
      logic [CNT_W-1:0] cnt_q;
      logic             wrap;

      assign wrap   = (cnt_q == CNT_W'(DIV - 1));
      assign tick_o = run_i & ~clr_i & wrap;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (!run_i || clr_i)   cnt_q <= '0;
        else if (wrap)              cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/cw_ms_counter.sv
module cw_ms_counter #(
  parameter int unsigned LIMIT_MS = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned MS_W = $clog2(LIMIT_MS + 1);

  logic [MS_W-1:0] ms_q;
  logic            at_limit;

  assign at_limit = (ms_q == MS_W'(LIMIT_MS));
  assign expire_o = tick_i & ~clr_i & (ms_q == MS_W'(LIMIT_MS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ms_q <= '0;
    else if (clr_i)               ms_q <= '0;
    else if (tick_i && !at_limit) ms_q <= ms_q + 1'b1;
  end
endmodule

// File: rtl/cw_arm_ctrl.sv
module cw_arm_ctrl
  import cw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic kick_i,
  input  logic disarm_i,
  input  logic expire_i,
  output logic active_o,
  output logic lost_o
);
  cw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (disarm_i) begin
      state_d = CW_OFF;
    end else begin
      unique case (state_q)
        CW_OFF:   if (arm_i) state_d = CW_WATCH;
        CW_WATCH: if (!kick_i && expire_i) state_d = CW_LOST;
        CW_LOST:  if (kick_i) state_d = CW_WATCH;
        default:  state_d = CW_OFF; // recover from illegal encoding
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CW_OFF;
    else         state_q <= state_d;
  end

  assign active_o = (state_q == CW_WATCH) || (state_q == CW_LOST);
  assign lost_o   = (state_q == CW_LOST);
endmodule

// File: rtl/comm_loss_wdog.sv
module comm_loss_wdog #(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned TIMEOUT_MS  = 96,
  parameter int unsigned ADDR_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dexg_done_i,
  input  logic              wpar_done_i,
  input  logic              del_addr_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  output logic              led_red_o,
  output logic              active_o
);
  localparam int unsigned TICK_DIV = CLK_FREQ_HZ / cw_pkg::TICKS_PER_SEC;

  logic addr_nz, kick, arm, disarm;
  logic active, lost, clr, tick, expire;

  assign addr_nz = |slave_addr_i;
  assign kick    = dexg_done_i | wpar_done_i;
  assign arm     = wpar_done_i & addr_nz;
  assign disarm  = del_addr_i | ~addr_nz;
  assign clr     = ~active | kick;

  cw_ms_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .clr_i  (clr),
    .tick_o (tick)
  );

  cw_ms_counter #(.LIMIT_MS(TIMEOUT_MS)) u_ms (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .tick_i   (tick),
    .expire_o (expire)
  );

  cw_arm_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .kick_i   (kick),
    .disarm_i (disarm),
    .expire_i (expire),
    .active_o (active),
    .lost_o   (lost)
  );

  assign led_red_o = lost;
  assign active_o  = active;
endmodule

// File: rtl/comm_loss_wdog_chk.sv
module comm_loss_wdog_chk #(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned TIMEOUT_MS  = 96,
  parameter int unsigned ADDR_W      = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dexg_done_i,
  input logic              wpar_done_i,
  input logic              del_addr_i,
  input logic [ADDR_W-1:0] slave_addr_i,
  input logic              led_red_o,
  input logic              active_o
);
  localparam int unsigned WIN = TIMEOUT_MS * (CLK_FREQ_HZ / 1000);

  logic [31:0] quiet_q;
  logic        req, nz;

  assign req = dexg_done_i | wpar_done_i;
  assign nz  = |slave_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                quiet_q <= '0;
    else if (!active_o || req)  quiet_q <= '0;
    else if (quiet_q != 32'hFFFF_FFFF) quiet_q <= quiet_q + 1'b1;
  end

  a_r10_led_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_red_o |-> active_o);

  a_r2_arm_on_wpar: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wpar_done_i && nz && !del_addr_i) |=> active_o);

  a_r7_delete_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    del_addr_i |=> (!active_o && !led_red_o));

  a_r8_zero_addr_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nz |=> !active_o);

  a_r5_request_clears_led: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && req && nz && !del_addr_i) |=> !led_red_o);

  a_r3_exact_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(led_red_o) |-> (quiet_q == WIN));
endmodule

bind comm_loss_wdog comm_loss_wdog_chk #(
  .CLK_FREQ_HZ(CLK_FREQ_HZ),
  .TIMEOUT_MS (TIMEOUT_MS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dexg_done_i  (dexg_done_i),
  .wpar_done_i  (wpar_done_i),
  .del_addr_i   (del_addr_i),
  .slave_addr_i (slave_addr_i),
  .led_red_o    (led_red_o),
  .active_o     (active_o)
);

// File: tb/comm_loss_wdog_tb_top.sv
`timescale 1ns/1ps
module comm_loss_wdog_tb_top;
  localparam int unsigned FREQ = 10_000;
  localparam int unsigned TMS  = 96;
  localparam int unsigned AW   = 5;
  localparam int unsigned WIN  = TMS * (FREQ / 1000);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dexg = 1'b0, wpar = 1'b0, del = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          led, act;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  comm_loss_wdog #(.CLK_FREQ_HZ(FREQ), .TIMEOUT_MS(TMS), .ADDR_W(AW)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .dexg_done_i  (dexg),
    .wpar_done_i  (wpar),
    .del_addr_i   (del),
    .slave_addr_i (addr),
    .led_red_o    (led),
    .active_o     (act)
  );

  task automatic chk(string req, string what, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // caller sits at a negedge; the pulse is sampled by the next posedge
  task automatic pulse(bit d, bit w, bit x);
    dexg = d; wpar = w; del = x;
    @(posedge clk);
    @(negedge clk);
    dexg = 1'b0; wpar = 1'b0; del = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "led after reset", led, 1'b0);
    chk("R1", "active after reset", act, 1'b0);
  endtask

  task automatic t_no_arm();
    addr = 5'd5;
    pulse(1, 0, 0);
    chk("R2", "dexg does not arm", act, 1'b0);
    addr = 5'd0;
    pulse(0, 1, 0);
    chk("R2", "wpar at addr 0 does not arm", act, 1'b0);
    addr = 5'd5;
    edges(WIN + 5);
    chk("R2", "led idle while unarmed", led, 1'b0);
  endtask

  task automatic t_arm_timeout();
    pulse(0, 1, 0);
    chk("R2", "wpar arms", act, 1'b1);
    edges(WIN - 1);
    chk("R3", "led low one edge before window", led, 1'b0);
    edges(1);
    chk("R3", "led high at window", led, 1'b1);
  endtask

  task automatic t_clear_after_loss();
    pulse(1, 0, 0);
    chk("R5", "dexg clears led", led, 1'b0);
    chk("R5", "still active", act, 1'b1);
    edges(WIN - 1);
    chk("R5", "new window not yet expired", led, 1'b0);
    edges(1);
    chk("R5", "new window expires", led, 1'b1);
  endtask

  task automatic t_kick_early();
    pulse(0, 1, 0);
    chk("R5", "wpar clears led", led, 1'b0);
    edges(WIN / 2);
    pulse(1, 0, 0);
    edges(WIN - 1);
    chk("R4", "window restarted by dexg", led, 1'b0);
    edges(1);
    chk("R4", "expires one window after dexg", led, 1'b1);
  endtask

  task automatic t_collision();
    pulse(1, 0, 0);
    edges(WIN - 1);
    chk("R6", "led low before collision", led, 1'b0);
    pulse(1, 0, 0); // sampled on the expiry edge
    chk("R6", "request beats expiry", led, 1'b0);
    edges(WIN - 1);
    chk("R6", "window restarted at collision", led, 1'b0);
    edges(1);
    chk("R6", "expires after restarted window", led, 1'b1);
  endtask

  task automatic t_delete();
    pulse(0, 0, 1);
    chk("R7", "delete clears active", act, 1'b0);
    chk("R10", "delete clears led", led, 1'b0);
    pulse(1, 0, 0);
    chk("R7", "dexg after delete no re-arm", act, 1'b0);
    edges(WIN + 5);
    chk("R7", "led stays off after delete", led, 1'b0);
  endtask

  task automatic t_del_vs_wpar();
    pulse(0, 1, 0);
    chk("R9", "armed before collision", act, 1'b1);
    pulse(0, 1, 1);
    chk("R9", "delete wins over wpar", act, 1'b0);
  endtask

  task automatic t_addr_zero();
    pulse(0, 1, 0);
    edges(WIN);
    chk("R8", "armed and lost", led, 1'b1);
    addr = '0;
    edges(1);
    chk("R8", "addr zero disarms", act, 1'b0);
    chk("R10", "led off when disarmed", led, 1'b0);
    addr = 5'd17;
    pulse(1, 0, 0);
    chk("R8", "stays disarmed on dexg", act, 1'b0);
  endtask

  task automatic t_rearm();
    pulse(0, 1, 0);
    chk("R2", "re-arm with wpar", act, 1'b1);
    edges(WIN - 1);
    chk("R3", "re-armed window low", led, 1'b0);
    edges(1);
    chk("R3", "re-armed window high", led, 1'b1);
  endtask

  initial begin
    #(20 * 200_000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_no_arm();
    t_arm_timeout();
    t_clear_after_loss();
    t_kick_early();
    t_collision();
    t_delete();
    t_del_vs_wpar();
    t_addr_zero();
    t_rearm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule